// File: doc/BRIEF.md
# External Sample Rate Meter

This block estimates the sample rate of one of several external digital audio receivers. It counts master-clock cycles (nominally 28.224 MHz) between consecutive frame-sync strobes from the chosen receiver and holds that period count as a 10-bit result. It then maps the period onto the nearest standard audio rate. The mapping compares the count against tick limits that are computed at elaboration, so the block needs no divider.

A result is produced only while the chosen receiver reports both a recovered clock and valid data. Changing the selected receiver, or losing either presence flag, clears the result and starts a settling window. After that window the first full frame period must be measured before the result is flagged valid. A freeze input keeps the displayed count steady while software reads it. If strobes stop arriving, the counter saturates and the block reports that no rate was found.

Top module: `srate_meter`

## Requirements
- R1: `tickCount` equals the number of rising clock edges between two consecutive selected frame-sync strobes. It updates on the edge that samples the second strobe.
- R2: The block computes f = floor(MCLK_HZ / tickCount) and assigns the rate code from the highest band whose floor f strictly exceeds. The bands, as code:floor:rateHz, are 15:184200:192000, 14:152200:176400, 13:112000:128000, 12:92100:96000, 11:76100:88200, 10:56000:64000, 9:46050:48000, 8:38050:44100, 7:28000:32000, 6:23025:24000, 5:19025:22050, 4:14000:16000, 3:11512:12000, 2:9512:11025 and 1:7000:8000. If f exceeds none of these floors, the code and `rateHz` are 0. `rateHz` is the rate paired with the code.
- R3: A `tickCount` of 0 yields code 0 and 0 Hz.
- R4: If no selected strobe arrives within 1023 edges of the previous one, `tickCount` becomes 1023. A count of 1023 always yields code 0 and 0 Hz.
- R5: While the selected receiver's clock-present or data-present flag is low, the block clears `tickCount`, the code, `rateHz` and `rateValid`. The clear takes effect on the next edge, and strobes have no effect while a flag is low.
- R6: While `freeze` is high, `tickCount` holds its value even when new periods complete. The period that ends after `freeze` is released is measured correctly.
- R7: A change of `srcSel` clears the result on the next edge. Strobes are then ignored for SETTLE_CYCLES edges, and `rateValid` stays low during that time.
- R8: `rateValid` rises only when a full period, started by a strobe after the settling window, has been loaded into `tickCount`.
- R9: Strobes on an input that is not selected do not affect the measurement.
- R10: After reset, `tickCount` is 0, `rateCode` is 0, `rateHz` is 0 and `rateValid` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master measurement clock |
| rstN | input | 1 | Active-low synchronous reset |
| frameSync | input | NUM_IN | One-cycle frame strobes, one per receiver |
| clkPresent | input | NUM_IN | Receiver clock-recovered flags |
| dataPresent | input | NUM_IN | Receiver data-valid flags |
| srcSel | input | SEL_W | Index of the measured receiver |
| freeze | input | 1 | Hold the displayed count |
| tickCount | output | CNT_W | Last measured period in clock ticks |
| rateCode | output | 4 | Classified rate code, 0 = none |
| rateHz | output | 18 | Standard rate for the code, in Hz |
| rateValid | output | 1 | A settled, complete measurement is shown |

## Verification
If the period counter is off by one, `tickCount` shows it on the edge that ends the next frame period. Near a band edge the code and `rateHz` also change, so the sweep probes counts on both sides of every reachable band limit. If the control state keeps stale progress across a source change or a loss of presence, `rateValid` rises too early, within the settling window or after a single strobe. Checks placed just after each of these events expose this. A broken freeze or saturation path shows on `tickCount` within one period.

// File: rtl/srm_pkg.sv
`timescale 1ns/1ps
package srm_pkg;

  localparam int NUM_CLASS = 15;
  localparam int CODE_W    = 4;
  localparam int HZ_W      = 18;

  // Standard rate, in Hz, for each code (ascending rate order).
  function automatic int unsigned classHz(input int code);
    case (code)
      1:  return 8000;
      2:  return 11025;
      3:  return 12000;
      4:  return 16000;
      5:  return 22050;
      6:  return 24000;
      7:  return 32000;
      8:  return 44100;
      9:  return 48000;
      10: return 64000;
      11: return 88200;
      12: return 96000;
      13: return 128000;
      14: return 176400;
      15: return 192000;
      default: return 0;
    endcase
  endfunction

  // Frequency the measured value must strictly exceed to reach this code.
  function automatic int unsigned classFloor(input int code);
    case (code)
      1:  return 7000;
      2:  return 9512;
      3:  return 11512;
      4:  return 14000;
      5:  return 19025;
      6:  return 23025;
      7:  return 28000;
      8:  return 38050;
      9:  return 46050;
      10: return 56000;
      11: return 76100;
      12: return 92100;
      13: return 112000;
      14: return 152200;
      15: return 184200;
      default: return 32'hFFFF_FFFF;
    endcase
  endfunction

  // floor(mclk / t) > floor  <=>  t <= floor(mclk / (floor + 1))
  function automatic int unsigned classMaxTicks(input int unsigned mclk, input int code);
    return mclk / (classFloor(code) + 1);
  endfunction

  typedef struct packed {
    logic clear;    // zero counter and held result
    logic restart;  // start a new period count at 1
    logic load;     // copy running count into held result
  } dpCtl_t;

  typedef enum logic [1:0] {
    ST_SETTLE = 2'd0,
    ST_ARM    = 2'd1,
    ST_MEAS   = 2'd2
  } mState_t;

endpackage

// File: rtl/srm_ctrl.sv
`timescale 1ns/1ps
module srm_ctrl
  import srm_pkg::*;
#(
  parameter int NUM_IN        = 2,
  parameter int SETTLE_CYCLES = 14112,
  localparam int SEL_W        = (NUM_IN > 1) ? $clog2(NUM_IN) : 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [NUM_IN-1:0] frameSync,
  input  logic [NUM_IN-1:0] clkPresent,
  input  logic [NUM_IN-1:0] dataPresent,
  input  logic [SEL_W-1:0]  srcSel,
  input  logic              freeze,
  input  logic              cntSat,
  output dpCtl_t            ctl,
  output logic              valid
);

  localparam int TMR_W = (SETTLE_CYCLES > 1) ? $clog2(SETTLE_CYCLES) : 1;
  localparam logic [TMR_W-1:0] TMR_LAST = TMR_W'(SETTLE_CYCLES - 1);

  mState_t          state, stateD;
  logic [TMR_W-1:0] tmr, tmrD;
  logic [SEL_W-1:0] selQ;
  logic             validD;
  logic             selPulse, present, selChange;

  assign selPulse  = frameSync[srcSel];
  assign present   = clkPresent[srcSel] & dataPresent[srcSel];
  assign selChange = (srcSel != selQ);

  always_comb begin
    ctl    = '0;
    stateD = state;
    tmrD   = tmr;
    validD = valid;
    if (!present || selChange) begin
      ctl.clear = 1'b1;
      stateD    = ST_SETTLE;
      tmrD      = '0;
      validD    = 1'b0;
    end else begin
      case (state)
        ST_SETTLE: begin
          if (tmr == TMR_LAST) stateD = ST_ARM;
          else                 tmrD   = tmr + TMR_W'(1);
        end
        ST_ARM: begin
          if (selPulse) begin
            ctl.restart = 1'b1;
            stateD      = ST_MEAS;
          end
        end
        ST_MEAS: begin
          if (selPulse) begin
            ctl.restart = 1'b1;
            ctl.load    = !freeze;
            if (!freeze) validD = 1'b1;
          end else if (cntSat) begin
            ctl.load = !freeze;
            if (!freeze) validD = 1'b1;
          end
        end
        default: stateD = ST_SETTLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state <= ST_SETTLE;
      tmr   <= '0;
      selQ  <= '0;
      valid <= 1'b0;
    end else begin
      state <= stateD;
      tmr   <= tmrD;
      selQ  <= srcSel;
      valid <= validD;
    end
  end

endmodule

// File: rtl/srm_datapath.sv
`timescale 1ns/1ps
module srm_datapath
  import srm_pkg::*;
#(
  parameter int CNT_W = 10
) (
  input  logic             clk,
  input  logic             rstN,
  input  dpCtl_t           ctl,
  output logic [CNT_W-1:0] meas,
  output logic             cntSat
);

  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic [CNT_W-1:0] cnt;

  assign cntSat = (cnt == CNT_MAX);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cnt  <= '0;
      meas <= '0;
    end else if (ctl.clear) begin
      cnt  <= '0;
      meas <= '0;
    end else begin
      if (ctl.load) meas <= cnt;
      if (ctl.restart)  cnt <= CNT_W'(1);
      else if (!cntSat) cnt <= cnt + CNT_W'(1);
    end
  end

endmodule

// File: rtl/srm_classify.sv
`timescale 1ns/1ps
module srm_classify
  import srm_pkg::*;
#(
  parameter int          CNT_W   = 10,
  parameter int unsigned MCLK_HZ = 28224000
) (
  input  logic [CNT_W-1:0]  ticks,
  output logic [CODE_W-1:0] code,
  output logic [HZ_W-1:0]   hz
);

  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic             usable;
  logic [NUM_CLASS-1:0] hit;

  assign usable = (ticks != '0) && (ticks != CNT_MAX);

  // Limits shrink as the rate rises, so the hits form a prefix and
  // their population count is the code.
  for (genvar c = 1; c <= NUM_CLASS; c++) begin : g_band
    localparam int unsigned LIM = classMaxTicks(MCLK_HZ, c);
    assign hit[c-1] = usable && (32'(ticks) <= LIM);
  end

  always_comb begin
    code = '0;
    for (int i = 0; i < NUM_CLASS; i++) code = code + CODE_W'(hit[i]);
    hz = HZ_W'(classHz(int'(code)));
  end

endmodule

// File: rtl/srate_meter.sv
`timescale 1ns/1ps
module srate_meter
  import srm_pkg::*;
#(
  parameter int          NUM_IN        = 2,
  parameter int          CNT_W         = 10,
  parameter int unsigned MCLK_HZ       = 28224000,
  parameter int          SETTLE_CYCLES = 14112,
  localparam int         SEL_W         = (NUM_IN > 1) ? $clog2(NUM_IN) : 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [NUM_IN-1:0] frameSync,
  input  logic [NUM_IN-1:0] clkPresent,
  input  logic [NUM_IN-1:0] dataPresent,
  input  logic [SEL_W-1:0]  srcSel,
  input  logic              freeze,
  output logic [CNT_W-1:0]  tickCount,
  output logic [3:0]        rateCode,
  output logic [17:0]       rateHz,
  output logic              rateValid
);

  dpCtl_t ctl;
  logic   cntSat;

  srm_ctrl #(.NUM_IN(NUM_IN), .SETTLE_CYCLES(SETTLE_CYCLES)) u_ctrl (
    .clk(clk), .rstN(rstN), .frameSync(frameSync), .clkPresent(clkPresent),
    .dataPresent(dataPresent), .srcSel(srcSel), .freeze(freeze),
    .cntSat(cntSat), .ctl(ctl), .valid(rateValid)
  );

  srm_datapath #(.CNT_W(CNT_W)) u_dp (
    .clk(clk), .rstN(rstN), .ctl(ctl), .meas(tickCount), .cntSat(cntSat)
  );

  srm_classify #(.CNT_W(CNT_W), .MCLK_HZ(MCLK_HZ)) u_cls (
    .ticks(tickCount), .code(rateCode), .hz(rateHz)
  );

endmodule

// File: rtl/srate_meter_chk.sv
`timescale 1ns/1ps
module srate_meter_chk #(
  parameter int NUM_IN = 2,
  parameter int CNT_W  = 10,
  localparam int SEL_W = (NUM_IN > 1) ? $clog2(NUM_IN) : 1
) (
  input logic              clk,
  input logic              rstN,
  input logic [NUM_IN-1:0] clkPresent,
  input logic [NUM_IN-1:0] dataPresent,
  input logic [SEL_W-1:0]  srcSel,
  input logic              freeze,
  input logic [CNT_W-1:0]  tickCount,
  input logic [3:0]        rateCode,
  input logic [17:0]       rateHz,
  input logic              rateValid
);

  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic [SEL_W-1:0] selPrev;
  logic             presentNow;

  assign presentNow = clkPresent[srcSel] & dataPresent[srcSel];

  always_ff @(posedge clk) begin
    if (!rstN) selPrev <= '0;
    else       selPrev <= srcSel;
  end

  // R5
  absent_clears_chk: assert property (@(posedge clk) disable iff (!rstN)
    !presentNow |=> (tickCount == '0 && rateCode == 4'd0 && !rateValid));

  // R6
  freeze_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (freeze && presentNow && srcSel == selPrev) |=> $stable(tickCount));

  // R7
  switch_blank_chk: assert property (@(posedge clk) disable iff (!rstN)
    (srcSel != selPrev) |=> (!rateValid && tickCount == '0));

  // R4
  sat_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    (tickCount == CNT_MAX) |-> (rateCode == 4'd0 && rateHz == 18'd0));

  // R2
  code_hz_pair_chk: assert property (@(posedge clk) disable iff (!rstN)
    (rateCode == 4'd0) == (rateHz == 18'd0));

  // R3
  zero_ticks_chk: assert property (@(posedge clk) disable iff (!rstN)
    (tickCount == '0) |-> (rateCode == 4'd0));

  // R8
  valid_nonzero_chk: assert property (@(posedge clk) disable iff (!rstN)
    rateValid |-> (tickCount != '0));

endmodule

bind srate_meter srate_meter_chk #(.NUM_IN(NUM_IN), .CNT_W(CNT_W)) u_chk (
  .clk(clk), .rstN(rstN), .clkPresent(clkPresent), .dataPresent(dataPresent),
  .srcSel(srcSel), .freeze(freeze), .tickCount(tickCount), .rateCode(rateCode),
  .rateHz(rateHz), .rateValid(rateValid)
);

// File: tb/srate_meter_tb.sv
`timescale 1ns/1ps
module srate_meter_tb;

  localparam int SETTLE = 64;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [1:0]  frameSync = '0;
  logic [1:0]  clkPresent = 2'b11;
  logic [1:0]  dataPresent = 2'b11;
  logic [0:0]  srcSel = '0;
  logic        freeze = 1'b0;
  logic [9:0]  tickCount;
  logic [3:0]  rateCode;
  logic [17:0] rateHz;
  logic        rateValid;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  always #10 clk = ~clk;

  srate_meter #(.SETTLE_CYCLES(SETTLE)) u_dut (
    .clk(clk), .rstN(rstN), .frameSync(frameSync), .clkPresent(clkPresent),
    .dataPresent(dataPresent), .srcSel(srcSel), .freeze(freeze),
    .tickCount(tickCount), .rateCode(rateCode), .rateHz(rateHz),
    .rateValid(rateValid)
  );

  function automatic int expHz(input int t);
    int f;
    if (t == 0 || t >= 1023) return 0;
    f = 28224000 / t;
    if (f > 184200) return 192000;
    if (f > 152200) return 176400;
    if (f > 112000) return 128000;
    if (f > 92100)  return 96000;
    if (f > 76100)  return 88200;
    if (f > 56000)  return 64000;
    if (f > 46050)  return 48000;
    if (f > 38050)  return 44100;
    if (f > 28000)  return 32000;
    if (f > 23025)  return 24000;
    if (f > 19025)  return 22050;
    if (f > 14000)  return 16000;
    if (f > 11512)  return 12000;
    if (f > 9512)   return 11025;
    if (f > 7000)   return 8000;
    return 0;
  endfunction

  function automatic int expCode(input int hz);
    case (hz)
      8000: return 1;    11025: return 2;   12000: return 3;
      16000: return 4;   22050: return 5;   24000: return 6;
      32000: return 7;   44100: return 8;   48000: return 9;
      64000: return 10;  88200: return 11;  96000: return 12;
      128000: return 13; 176400: return 14; 192000: return 15;
      default: return 0;
    endcase
  endfunction

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic pulseOnce(input int idx);
    frameSync[idx] = 1'b1;
    @(negedge clk);
    frameSync[idx] = 1'b0;
  endtask

  // Ends a period of n edges on input idx and checks the result (R1, R2).
  task automatic periodCheck(input int idx, input int n);
    int t;
    repeat (n - 1) @(negedge clk);
    pulseOnce(idx);
    t = (n > 1023) ? 1023 : n;
    chk("R1", "tickCount", int'(tickCount), t);
    chk("R2", "rateHz", int'(rateHz), expHz(t));
    chk("R2", "rateCode", int'(rateCode), expCode(expHz(t)));
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1;
      fails++; checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    int bounds[24] = '{1, 2, 152, 153, 154, 185, 186, 251, 252, 306, 307,
                       370, 371, 503, 504, 588, 612, 613, 640, 741, 742,
                       1007, 1008, 1022};
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    // R10, R3: reset state
    chk("R10", "tickCount", int'(tickCount), 0);
    chk("R10", "rateValid", int'(rateValid), 0);
    chk("R3", "rateCode", int'(rateCode), 0);
    chk("R3", "rateHz", int'(rateHz), 0);

    // R8: valid only after a full period following settle
    repeat (SETTLE + 8) @(negedge clk);
    pulseOnce(0);
    chk("R8", "valid after first strobe", int'(rateValid), 0);
    periodCheck(0, 588);
    chk("R8", "valid after full period", int'(rateValid), 1);

    // R1, R2: sweep of periods and every reachable band edge
    for (int n = 3; n < 1023; n += 13) periodCheck(0, n);
    foreach (bounds[i]) periodCheck(0, bounds[i]);
    periodCheck(0, 1023);   // R4: exact limit reads as no rate

    // R9: strobe on the other input mid-period
    repeat (249) @(negedge clk);
    pulseOnce(1);
    repeat (249) @(negedge clk);
    pulseOnce(0);
    chk("R9", "tickCount", int'(tickCount), 500);

    // R6: freeze holds the count
    freeze = 1'b1;
    repeat (199) @(negedge clk);
    pulseOnce(0);
    chk("R6", "frozen tickCount", int'(tickCount), 500);
    repeat (299) @(negedge clk);
    pulseOnce(0);
    chk("R6", "frozen tickCount", int'(tickCount), 500);
    freeze = 1'b0;
    periodCheck(0, 400);
    chk("R6", "after release", int'(tickCount), 400);

    // R4: strobes stop, counter saturates
    repeat (1100) @(negedge clk);
    chk("R4", "tickCount", int'(tickCount), 1023);
    chk("R4", "rateCode", int'(rateCode), 0);
    chk("R4", "rateHz", int'(rateHz), 0);
    pulseOnce(0);
    periodCheck(0, 300);

    // R5: data flag drops
    dataPresent[0] = 1'b0;
    @(negedge clk);
    chk("R5", "tickCount", int'(tickCount), 0);
    chk("R5", "rateCode", int'(rateCode), 0);
    chk("R5", "rateValid", int'(rateValid), 0);
    pulseOnce(0);
    repeat (20) @(negedge clk);
    pulseOnce(0);
    chk("R5", "tickCount while absent", int'(tickCount), 0);
    dataPresent[0] = 1'b1;
    clkPresent[0] = 1'b0;
    @(negedge clk);
    chk("R5", "clk flag low valid", int'(rateValid), 0);
    clkPresent[0] = 1'b1;
    repeat (SETTLE + 8) @(negedge clk);
    pulseOnce(0);
    periodCheck(0, 250);

    // R7: source change blanks and settles
    srcSel = 1'b1;
    @(negedge clk);
    chk("R7", "tickCount after switch", int'(tickCount), 0);
    chk("R7", "rateValid after switch", int'(rateValid), 0);
    repeat (10) @(negedge clk);
    pulseOnce(1);
    repeat (30) @(negedge clk);
    pulseOnce(1);
    chk("R7", "valid in settle", int'(rateValid), 0);
    chk("R7", "tickCount in settle", int'(tickCount), 0);
    repeat (SETTLE) @(negedge clk);
    pulseOnce(1);
    chk("R8", "valid after prime", int'(rateValid), 0);
    periodCheck(1, 588);
    chk("R7", "rateCode on new input", int'(rateCode), 9);
    chk("R8", "valid on new input", int'(rateValid), 1);

    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

endmodule